// File: doc/BRIEF.md
# Two-Way Page Translation Cache

This block holds recently used virtual-to-physical page translations so that a processor core can turn a 32-bit virtual address into a physical one without walking the page table. Pages are 4 KiB. Instruction fetches and data accesses use two separate arrays. Each array has 64 sets of two ways. A single recency bit per set chooses the way that a refill replaces.

Translation is combinational. The core presents an address and an access type, and `lkHit` and `lkPaddr` are valid in the same cycle. When `lkEn` is high, the lookup also updates state at the next clock edge. A hit updates the set's recency bit, and a write to a clean page sets its changed bit.

After a miss, the page-table walker outside this block delivers the page entry through the refill port. Software-driven shootdowns use the invalidate port, which clears one set index in both arrays.

Top module: `xlat_tlb`

## Requirements
- R1: After reset every way of both arrays holds the invalid tag, and a lookup misses for every address. This includes virtual page number 0xFFFFF and page number 0.
- R2: A lookup hits when a way of set `addr[17:12]` holds the full virtual page number `addr[31:12]`. On a hit, `lkPaddr` is {entry bits [31:12], `addr[11:0]`}.
- R3: The access type is encoded as 0 = fetch, 1 = read, 2 = write and 3 = probe. Type 0 uses the instruction array and types 1 to 3 use the data array, for both lookup and refill.
- R4: A refill writes way 1 when the set's recency bit is 0 and way 0 holds a valid tag. Otherwise it writes way 0. The recency bit then takes the number of the way written.
- R5: A hit with `lkEn` high and a type other than probe sets the recency bit to the way that hit. A probe never changes recency.
- R6: Entry bit 7 is the changed bit. A write lookup that matches an entry whose bit 7 is 0 reports a miss. With `lkEn` high, bit 7 becomes 1 at the next edge, so a later write lookup to that page hits.
- R7: A refill whose type is probe leaves the arrays unchanged.
- R8: Invalidate marks both ways of set `invAddr[17:12]` invalid in both arrays. Other sets keep their contents.
- R9: When refill and invalidate address the same set in one cycle, the refill is dropped. A refill to another set in that cycle still takes effect.
- R10: When a lookup with side effects and a refill hit the same set in one cycle, the refill's recency value is the one kept.
- R11: State written by refill, invalidate or a side-effecting lookup is visible to lookups from the cycle after the edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| lkAddr | input | 32 | Lookup virtual address |
| lkType | input | 2 | Lookup access type |
| lkEn | input | 1 | Lookup side effects enabled this cycle |
| lkHit | output | 1 | Translation found |
| lkPaddr | output | 32 | Translated physical address |
| rfEn | input | 1 | Refill request |
| rfAddr | input | 32 | Refill virtual address |
| rfType | input | 2 | Refill access type |
| rfPte | input | 32 | Page entry word: real page number in [31:12], changed bit in 7 |
| invEn | input | 1 | Invalidate request |
| invAddr | input | 32 | Invalidate virtual address |

## Verification
Two pairs of operations can fall in the same cycle on one set: a refill with an invalidate, and a recency-updating lookup with a refill. The bench drives each pair in a single cycle on a set already loaded with known entries.

The first pair is judged by whether the refilled page misses afterward, while a refill to a different set in that cycle still hits. The second pair is judged by a follow-up refill whose way choice exposes which recency value survived. A check then shows which older page was evicted.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2,
    ACC_PROBE = 2'd3
  } acc_e;

  // Strobes from control to the storage datapath
  typedef struct packed {
    logic lkWay;     // way that the lookup matched
    logic lkSetC;    // set changed bit of that way
    logic lkSetRec;  // move recency to lkWay
    logic rfDo;      // perform refill
    logic rfWay;     // way chosen for refill
    logic invDo;     // invalidate addressed set in both arrays
  } strobe_t;

endpackage

// File: rtl/xlat_store.sv
module xlat_store
  import xlat_pkg::*;
#(
  parameter int VA_W      = 32,
  parameter int PAGE_BITS = 12,
  parameter int SET_BITS  = 6,
  parameter int C_BIT     = 7
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          lkInstr,
  input  logic [VA_W-PAGE_BITS-1:0]     lkVpn,
  input  logic                          rfInstr,
  input  logic [VA_W-PAGE_BITS-1:0]     rfVpn,
  input  logic [VA_W-1:0]               rfPte,
  input  logic [SET_BITS-1:0]           invSet,
  input  strobe_t                       st,
  output logic [1:0]                    lkMatch,
  output logic [1:0]                    lkCbit,
  output logic [VA_W-PAGE_BITS-1:0]     lkRpn0,
  output logic [VA_W-PAGE_BITS-1:0]     lkRpn1,
  output logic                          rfRec,
  output logic                          rfTag0Valid
);
  localparam int VPN_W = VA_W - PAGE_BITS;
  localparam int TAG_W = VPN_W + 1;          // extra bit keeps invalid unreachable
  localparam int SETS  = 1 << SET_BITS;
  localparam logic [TAG_W-1:0] INV_TAG = '1;

  logic [SET_BITS-1:0] lkSet, rfSet;
  assign lkSet = lkVpn[SET_BITS-1:0];
  assign rfSet = rfVpn[SET_BITS-1:0];

  logic [1:0]       matchArr [2];
  logic [1:0]       cbitArr  [2];
  logic [VPN_W-1:0] rpnArr   [2][2];
  logic             recArr   [2];
  logic             t0vArr   [2];

  for (genvar a = 0; a < 2; a++) begin : g_arr
    logic [TAG_W-1:0] tagMem [SETS][2];
    logic [VPN_W-1:0] rpnMem [SETS][2];
    logic [VA_W-1:0]  pteMem [SETS][2];
    logic             recMem [SETS];
    logic             lkSel, rfSel;

    assign lkSel = (lkInstr == 1'(a));
    assign rfSel = (rfInstr == 1'(a));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        for (int s = 0; s < SETS; s++) begin
          recMem[s] <= 1'b0;
          for (int w = 0; w < 2; w++) begin
            tagMem[s][w] <= INV_TAG;
            rpnMem[s][w] <= '0;
            pteMem[s][w] <= '0;
          end
        end
      end else begin
        if (lkSel && st.lkSetC)   pteMem[lkSet][st.lkWay][C_BIT] <= 1'b1;
        if (lkSel && st.lkSetRec) recMem[lkSet] <= st.lkWay;
        // refill comes later so its writes win over the lookup's
        if (rfSel && st.rfDo) begin
          tagMem[rfSet][st.rfWay] <= {1'b0, rfVpn};
          rpnMem[rfSet][st.rfWay] <= rfPte[VA_W-1:PAGE_BITS];
          pteMem[rfSet][st.rfWay] <= rfPte;
          recMem[rfSet]           <= st.rfWay;
        end
        if (st.invDo) begin
          tagMem[invSet][0] <= INV_TAG;
          tagMem[invSet][1] <= INV_TAG;
        end
      end
    end

    assign matchArr[a] = {tagMem[lkSet][1] == {1'b0, lkVpn},
                          tagMem[lkSet][0] == {1'b0, lkVpn}};
    assign cbitArr[a]  = {pteMem[lkSet][1][C_BIT], pteMem[lkSet][0][C_BIT]};
    assign rpnArr[a][0] = rpnMem[lkSet][0];
    assign rpnArr[a][1] = rpnMem[lkSet][1];
    assign recArr[a]   = recMem[rfSet];
    assign t0vArr[a]   = (tagMem[rfSet][0] != INV_TAG);
  end

  assign lkMatch     = matchArr[lkInstr];
  assign lkCbit      = cbitArr[lkInstr];
  assign lkRpn0      = rpnArr[lkInstr][0];
  assign lkRpn1      = rpnArr[lkInstr][1];
  assign rfRec       = recArr[rfInstr];
  assign rfTag0Valid = t0vArr[rfInstr];

endmodule

// File: rtl/xlat_ctrl.sv
module xlat_ctrl
  import xlat_pkg::*;
#(
  parameter int VA_W      = 32,
  parameter int PAGE_BITS = 12,
  parameter int SET_BITS  = 6
) (
  input  logic                      lkEn,
  input  acc_e                      lkType,
  input  logic [PAGE_BITS-1:0]      lkOffset,
  input  logic [1:0]                lkMatch,
  input  logic [1:0]                lkCbit,
  input  logic [VA_W-PAGE_BITS-1:0] lkRpn0,
  input  logic [VA_W-PAGE_BITS-1:0] lkRpn1,
  input  logic                      rfEn,
  input  acc_e                      rfType,
  input  logic [SET_BITS-1:0]       rfSet,
  input  logic                      rfRec,
  input  logic                      rfTag0Valid,
  input  logic                      invEn,
  input  logic [SET_BITS-1:0]       invSet,
  output strobe_t                   st,
  output logic                      lkHit,
  output logic [VA_W-1:0]           lkPaddr
);
  logic anyMatch, hitWay, cleanWrite;

  always_comb begin
    anyMatch   = |lkMatch;
    hitWay     = lkMatch[1] & ~lkMatch[0];   // way 0 preferred
    cleanWrite = anyMatch && (lkType == ACC_WRITE) && !lkCbit[hitWay];
    lkHit      = anyMatch && !cleanWrite;
    lkPaddr    = {(hitWay ? lkRpn1 : lkRpn0), lkOffset};

    st.lkWay    = hitWay;
    st.lkSetC   = lkEn && cleanWrite;
    st.lkSetRec = lkEn && lkHit && (lkType != ACC_PROBE);
    st.invDo    = invEn;
    st.rfDo     = rfEn && (rfType != ACC_PROBE) && !(invEn && (invSet == rfSet));
    st.rfWay    = !rfRec && rfTag0Valid;
  end

endmodule

// File: rtl/xlat_tlb.sv
module xlat_tlb
  import xlat_pkg::*;
#(
  parameter int VA_W      = 32,
  parameter int PAGE_BITS = 12,
  parameter int SET_BITS  = 6,
  parameter int C_BIT     = 7
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [VA_W-1:0] lkAddr,
  input  logic [1:0]      lkType,
  input  logic            lkEn,
  output logic            lkHit,
  output logic [VA_W-1:0] lkPaddr,
  input  logic            rfEn,
  input  logic [VA_W-1:0] rfAddr,
  input  logic [1:0]      rfType,
  input  logic [VA_W-1:0] rfPte,
  input  logic            invEn,
  input  logic [VA_W-1:0] invAddr
);
  localparam int VPN_W = VA_W - PAGE_BITS;

  strobe_t          st;
  acc_e             lkAcc, rfAcc;
  logic [1:0]       lkMatch, lkCbit;
  logic [VPN_W-1:0] lkRpn0, lkRpn1;
  logic             rfRec, rfTag0Valid;

  assign lkAcc = acc_e'(lkType);
  assign rfAcc = acc_e'(rfType);

  xlat_store #(.VA_W(VA_W), .PAGE_BITS(PAGE_BITS), .SET_BITS(SET_BITS), .C_BIT(C_BIT)) u_store (
    .clk        (clk),
    .rstN       (rstN),
    .lkInstr    (lkAcc == ACC_FETCH),
    .lkVpn      (lkAddr[VA_W-1:PAGE_BITS]),
    .rfInstr    (rfAcc == ACC_FETCH),
    .rfVpn      (rfAddr[VA_W-1:PAGE_BITS]),
    .rfPte      (rfPte),
    .invSet     (invAddr[PAGE_BITS +: SET_BITS]),
    .st         (st),
    .lkMatch    (lkMatch),
    .lkCbit     (lkCbit),
    .lkRpn0     (lkRpn0),
    .lkRpn1     (lkRpn1),
    .rfRec      (rfRec),
    .rfTag0Valid(rfTag0Valid)
  );

  xlat_ctrl #(.VA_W(VA_W), .PAGE_BITS(PAGE_BITS), .SET_BITS(SET_BITS)) u_ctrl (
    .lkEn       (lkEn),
    .lkType     (lkAcc),
    .lkOffset   (lkAddr[PAGE_BITS-1:0]),
    .lkMatch    (lkMatch),
    .lkCbit     (lkCbit),
    .lkRpn0     (lkRpn0),
    .lkRpn1     (lkRpn1),
    .rfEn       (rfEn),
    .rfType     (rfAcc),
    .rfSet      (rfAddr[PAGE_BITS +: SET_BITS]),
    .rfRec      (rfRec),
    .rfTag0Valid(rfTag0Valid),
    .invEn      (invEn),
    .invSet     (invAddr[PAGE_BITS +: SET_BITS]),
    .st         (st),
    .lkHit      (lkHit),
    .lkPaddr    (lkPaddr)
  );

endmodule

// File: rtl/xlat_tlb_checker.sv
module xlat_tlb_checker #(
  parameter int VA_W      = 32,
  parameter int PAGE_BITS = 12,
  parameter int SET_BITS  = 6
) (
  input logic            clk,
  input logic            rstN,
  input logic [VA_W-1:0] lkAddr,
  input logic [1:0]      lkType,
  input logic            lkHit,
  input logic [VA_W-1:0] lkPaddr,
  input logic            rfEn,
  input logic [VA_W-1:0] rfAddr,
  input logic [1:0]      rfType,
  input logic [VA_W-1:0] rfPte,
  input logic            invEn,
  input logic [VA_W-1:0] invAddr
);
  // R1: first cycle out of reset, nothing hits
  p_reset_empty_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> !lkHit);

  // R2: page offset passes through unchanged on a hit
  p_offset_pass_r2: assert property (@(posedge clk) disable iff (!rstN)
    lkHit |-> lkPaddr[PAGE_BITS-1:0] == lkAddr[PAGE_BITS-1:0]);

  // R11: a surviving refill is seen by a matching non-write lookup next cycle
  p_refill_visible_r11: assert property (@(posedge clk) disable iff (!rstN)
    (rfEn && rfType != 2'd3 &&
     !(invEn && invAddr[PAGE_BITS +: SET_BITS] == rfAddr[PAGE_BITS +: SET_BITS]))
    |=> ((lkAddr == $past(rfAddr) && lkType == $past(rfType) && lkType != 2'd2)
         -> (lkHit && lkPaddr[VA_W-1:PAGE_BITS] == $past(rfPte[VA_W-1:PAGE_BITS]))));

  // R8: invalidated set cannot hit in the following cycle
  p_inv_clears_r8: assert property (@(posedge clk) disable iff (!rstN)
    invEn |=> !(lkHit && lkAddr[PAGE_BITS +: SET_BITS] == $past(invAddr[PAGE_BITS +: SET_BITS])));
endmodule

bind xlat_tlb xlat_tlb_checker #(.VA_W(VA_W), .PAGE_BITS(PAGE_BITS), .SET_BITS(SET_BITS)) u_chk (
  .clk(clk), .rstN(rstN), .lkAddr(lkAddr), .lkType(lkType), .lkHit(lkHit),
  .lkPaddr(lkPaddr), .rfEn(rfEn), .rfAddr(rfAddr), .rfType(rfType),
  .rfPte(rfPte), .invEn(invEn), .invAddr(invAddr)
);

// File: tb/test_xlat_tlb.sv
module test_xlat_tlb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] lkAddr = '0;
  logic [1:0]  lkType = '0;
  logic        lkEn = 1'b0;
  logic        lkHit;
  logic [31:0] lkPaddr;
  logic        rfEn = 1'b0;
  logic [31:0] rfAddr = '0;
  logic [1:0]  rfType = '0;
  logic [31:0] rfPte = '0;
  logic        invEn = 1'b0;
  logic [31:0] invAddr = '0;

  localparam logic [1:0] FETCH = 2'd0, READ = 2'd1, WRITE = 2'd2, PROBE = 2'd3;

  int checks = 0;
  int fails  = 0;

  typedef struct {
    logic        hit;
    logic [31:0] pa;
    logic [31:0] va;
    string       req;
  } exp_t;
  exp_t expQ[$];

  always #4 clk = ~clk;   // 125 MHz

  xlat_tlb i_xlat_tlb (
    .clk(clk), .rstN(rstN), .lkAddr(lkAddr), .lkType(lkType), .lkEn(lkEn),
    .lkHit(lkHit), .lkPaddr(lkPaddr), .rfEn(rfEn), .rfAddr(rfAddr),
    .rfType(rfType), .rfPte(rfPte), .invEn(invEn), .invAddr(invAddr)
  );

  function automatic logic [31:0] mkPte(input logic [19:0] rpn, input logic c);
    return {rpn, 4'h0, c, 7'h0};
  endfunction

  task automatic step(input logic [31:0] la, input logic [1:0] lt, input logic le,
                      input logic re, input logic [31:0] ra, input logic [1:0] rt,
                      input logic [31:0] rp, input logic ie, input logic [31:0] ia);
    @(negedge clk);
    lkAddr = la; lkType = lt; lkEn = le;
    rfEn = re; rfAddr = ra; rfType = rt; rfPte = rp;
    invEn = ie; invAddr = ia;
  endtask

  task automatic expect_now(input logic [31:0] va, input logic hit,
                            input logic [19:0] rpn, input string req);
    exp_t e;
    e.hit = hit; e.pa = {rpn, va[11:0]}; e.va = va; e.req = req;
    expQ.push_back(e);
  endtask

  task automatic look(input logic [31:0] va, input logic [1:0] t, input logic en,
                      input logic hit, input logic [19:0] rpn, input string req);
    step(va, t, en, 1'b0, '0, READ, '0, 1'b0, '0);
    expect_now(va, hit, rpn, req);
  endtask

  task automatic refill(input logic [31:0] va, input logic [1:0] t, input logic [31:0] pte);
    step('0, READ, 1'b0, 1'b1, va, t, pte, 1'b0, '0);
  endtask

  // monitor: compares queued expectations away from the clock edge
  initial begin
    forever begin
      @(negedge clk);
      #2;
      while (expQ.size() > 0) begin
        exp_t e;
        e = expQ.pop_front();
        checks++;
        if (lkHit !== e.hit) begin
          fails++;
          $display("FAIL %s va=%h hit actual=%b expected=%b", e.req, e.va, lkHit, e.hit);
        end else if (e.hit && lkPaddr !== e.pa) begin
          fails++;
          $display("FAIL %s va=%h paddr actual=%h expected=%h", e.req, e.va, lkPaddr, e.pa);
        end
      end
    end
  end

  initial begin
    #(8 * 20000);
    fails++;
    $display("FAIL watchdog expired: actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: empty after reset
    look(32'h0000_0000, FETCH, 0, 0, 0, "R1");
    look(32'h0000_0000, READ,  0, 0, 0, "R1");
    look(32'hFFFF_F000, READ,  0, 0, 0, "R1");

    // R2: full-width page number, offset passthrough
    refill(32'hFFFF_F800, READ, mkPte(20'hABCDE, 1'b1));
    look(32'hFFFF_F800, READ, 0, 1, 20'hABCDE, "R2");
    look(32'hFFFF_F123, READ, 0, 1, 20'hABCDE, "R2");
    look(32'h0003_F800, READ, 0, 0, 0, "R2");   // same set, other tag

    // R4/R5: replacement order in set 5 (data array)
    refill(32'h0000_5123, READ, mkPte(20'h11111, 1'b1));  // A -> way0
    refill(32'h0004_5abc, READ, mkPte(20'h22222, 1'b1));  // B -> way1
    look(32'h0000_5123, READ, 0, 1, 20'h11111, "R4");
    look(32'h0004_5abc, READ, 0, 1, 20'h22222, "R4");
    refill(32'h0008_5000, READ, mkPte(20'h33333, 1'b1));  // C -> way0
    look(32'h0000_5123, READ, 0, 0, 0, "R4");
    look(32'h0004_5abc, READ, 0, 1, 20'h22222, "R4");
    look(32'h0008_5000, READ, 0, 1, 20'h33333, "R4");
    look(32'h0004_5abc, READ, 1, 1, 20'h22222, "R5");    // recency -> 1
    refill(32'h000C_5444, READ, mkPte(20'h44444, 1'b1));  // D -> way0
    look(32'h0008_5000, READ, 0, 0, 0, "R5");
    look(32'h0004_5abc, READ, 0, 1, 20'h22222, "R5");
    look(32'h0004_5abc, PROBE, 1, 1, 20'h22222, "R5");   // no recency change
    refill(32'h0010_5fff, READ, mkPte(20'h55555, 1'b1));  // E -> way1
    look(32'h0004_5abc, READ, 0, 0, 0, "R5");
    look(32'h000C_5444, READ, 0, 1, 20'h44444, "R5");
    look(32'h0010_5fff, READ, 0, 1, 20'h55555, "R5");

    // R6/R11: changed bit on a clean page
    refill(32'h0001_9010, READ, mkPte(20'h66666, 1'b0));
    look(32'h0001_9010, READ,  0, 1, 20'h66666, "R6");
    look(32'h0001_9010, WRITE, 0, 0, 0, "R6");
    look(32'h0001_9010, WRITE, 1, 0, 0, "R6");
    look(32'h0001_9010, WRITE, 0, 1, 20'h66666, "R11");

    // R3: separate instruction and data arrays
    refill(32'h0002_A020, FETCH, mkPte(20'h77777, 1'b1));
    look(32'h0002_A020, READ,  0, 0, 0, "R3");
    look(32'h0002_A020, FETCH, 0, 1, 20'h77777, "R3");
    refill(32'h0002_A020, WRITE, mkPte(20'h78787, 1'b1));
    look(32'h0002_A020, READ,  0, 1, 20'h78787, "R3");
    look(32'h0002_A020, FETCH, 0, 1, 20'h77777, "R3");

    // R7: probe refill ignored
    refill(32'h0003_B000, PROBE, mkPte(20'h88888, 1'b1));
    look(32'h0003_B000, READ,  0, 0, 0, "R7");
    look(32'h0003_B000, PROBE, 0, 0, 0, "R7");

    // R8: invalidate set 0x11 in both arrays
    refill(32'h0001_1000, FETCH, mkPte(20'h99999, 1'b1));
    refill(32'h0005_1000, READ,  mkPte(20'h9999A, 1'b1));
    look(32'h0001_1000, FETCH, 0, 1, 20'h99999, "R8");
    step('0, READ, 0, 0, '0, READ, '0, 1, 32'h00C1_1abc);
    look(32'h0001_1000, FETCH, 0, 0, 0, "R8");
    look(32'h0005_1000, READ,  0, 0, 0, "R8");
    look(32'h0010_5fff, READ,  0, 1, 20'h55555, "R8");

    // R9: refill and invalidate in the same cycle
    step('0, READ, 0, 1, 32'h0001_3000, READ, mkPte(20'hAAAAA, 1'b1), 1, 32'h0009_3000);
    look(32'h0001_3000, READ, 0, 0, 0, "R9");
    step('0, READ, 0, 1, 32'h0001_4000, READ, mkPte(20'hBBBBB, 1'b1), 1, 32'h0009_3000);
    look(32'h0001_4000, READ, 0, 1, 20'hBBBBB, "R9");

    // R10: lookup recency and refill recency on the same set
    refill(32'h0001_6000, READ, mkPte(20'hC0000, 1'b1));   // P -> way0
    refill(32'h0005_6000, READ, mkPte(20'hC1111, 1'b1));   // Q -> way1, rec=1
    step(32'h0005_6000, READ, 1, 1, 32'h0009_6000, READ, mkPte(20'hC2222, 1'b1), 0, '0);
    expect_now(32'h0005_6000, 1, 20'hC1111, "R10");
    refill(32'h000D_6000, READ, mkPte(20'hC3333, 1'b1));   // S -> way1 if rec=0
    look(32'h0005_6000, READ, 0, 0, 0, "R10");
    look(32'h0009_6000, READ, 0, 1, 20'hC2222, "R10");
    look(32'h000D_6000, READ, 0, 1, 20'hC3333, "R10");
    look(32'h0001_6000, READ, 0, 0, 0, "R10");

    step('0, READ, 0, 0, '0, READ, '0, 0, '0);
    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule